// File: doc/BRIEF.md
# Variable Page-Size Translation Buffer

This block is a small, fully associative address translation buffer. Each entry holds one tag for a pair of adjacent virtual pages, plus two physical mappings: one for the even page of the pair and one for the odd page. A per-entry size mask sets the page size to 1 KB, 4 KB, 16 KB, 64 KB or 256 KB. The translate port is combinational. It takes a 32-bit virtual address, the current address space ID and a store flag. It returns a physical address and an exception code in the same cycle.

Entries are managed through a set of staging registers: a tag register, an even-half register, an odd-half register, a size-mask register and an index register. A write port loads each of them. Four command pulses act on the table:

- **probe** searches the table for the tag register's page pair.
- **indexed write** copies the staging registers into the entry chosen by the index register.
- **random write** copies the staging registers into the entry chosen by a free-running replacement counter.
- **indexed read** copies an entry back into the staging registers.

When a translation that is marked valid faults, the tag register captures the faulting page-pair number and address space ID. Software can then refill the entry.

Top module: `pgtlb`

## Requirements
- R1: While reset is active, the tag, even-half, odd-half, mask and index registers read 0, and the replacement counter reads ENTRIES-1.
- R2: `mg_we` writes the register chosen by `mg_sel` (0 tag, 1 even half, 2 odd half, 3 mask, 4 index). Only these bits are kept: tag keeps bits 31:11 (page-pair number) and ASIDW-1:0 (ASID); each half keeps 25:4 (frame number), 2 (dirty), 1 (valid) and 0 (global); the mask keeps 18:11; the index keeps bit 31 (probe failed) and its low index bits. All other bits read 0.
- R3: An entry matches when virtual address bits 31:11 equal its tag in every bit that its mask leaves clear. The mask patterns 00h, 03h, 0Fh, 3Fh and FFh select 1, 4, 16, 64 and 256 KB.
- R4: The even/odd select bit is address bit 10 plus the number of set mask bits. A 0 in that bit selects the even half and a 1 selects the odd half. The physical address is the selected frame number shifted left by 10, with every bit below the select bit taken from the virtual address.
- R5: A match needs the entry's ASID to equal `xl_asid`, unless the entry was written while both halves had their global bit set.
- R6: `xl_exc` is 00 on success, 01 on miss, 10 when the selected half is not valid, and 11 on a store to a valid half whose dirty bit is clear. On any exception `xl_paddr` is 0.
- R7: When `xl_valid` is high and `xl_exc` is not 00, the tag register loads virtual address bits 31:11 and `xl_asid` at the next edge. Otherwise, translation leaves it unchanged.
- R8: A probe compares the tag register with each entry under the R3 and R5 rules. On a match it writes the matching index into the index register. On no match it writes only bit 31 set.
- R9: An indexed write stores the tag, mask and both halves into the entry selected by the index register. The entry's global flag is the AND of the two halves' global bits. An indexed read returns that content to the staging registers, with the global flag copied to both halves.
- R10: The replacement counter decrements once per cycle and wraps from WIRED back to ENTRIES-1. A random write uses the counter's value in that cycle as the entry index.
- R11: A stored mask that is not one of the five patterns acts as 00h (1 KB) for matching and for choosing the select bit.
- R12: When several entries match, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_valid | input | 1 | Translation is real; a fault updates the tag register |
| xl_store | input | 1 | Access is a store |
| xl_vaddr | input | 32 | Virtual address |
| xl_asid | input | ASIDW | Current address space ID |
| xl_paddr | output | 32 | Physical address (0 on exception) |
| xl_exc | output | 2 | Exception code |
| mg_we | input | 1 | Staging register write strobe |
| mg_sel | input | 3 | Staging register select |
| mg_wdata | input | 32 | Staging register write data |
| cmd_probe | input | 1 | Probe command pulse |
| cmd_wi | input | 1 | Indexed write command pulse |
| cmd_wr | input | 1 | Random write command pulse |
| cmd_rd | input | 1 | Indexed read command pulse |
| hi_q | output | 32 | Tag register |
| lo0_q | output | 32 | Even-half register |
| lo1_q | output | 32 | Odd-half register |
| mask_q | output | 32 | Mask register |
| index_q | output | 32 | Index register |
| random_q | output | $clog2(ENTRIES) | Replacement counter |

## Verification
The assertions assume that a cycle carries at most one of these: a staging write, a command pulse, or a valid faulting translation. The hold checks on the tag and index registers exclude those cycles explicitly. The stimulus drives each staging write and each command as a single isolated pulse. It keeps `xl_valid` low except in the dedicated capture scenario, so the combinational lookups never race a table update.

// File: rtl/pgtlb.sv
module pgtlb #(
  parameter int ENTRIES = 8,
  parameter int WIRED   = 2,
  parameter int ASIDW   = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xl_valid,
  input  logic             xl_store,
  input  logic [31:0]      xl_vaddr,
  input  logic [ASIDW-1:0] xl_asid,
  output logic [31:0]      xl_paddr,
  output logic [1:0]       xl_exc,
  input  logic             mg_we,
  input  logic [2:0]       mg_sel,
  input  logic [31:0]      mg_wdata,
  input  logic             cmd_probe,
  input  logic             cmd_wi,
  input  logic             cmd_wr,
  input  logic             cmd_rd,
  output logic [31:0]      hi_q,
  output logic [31:0]      lo0_q,
  output logic [31:0]      lo1_q,
  output logic [31:0]      mask_q,
  output logic [31:0]      index_q,
  output logic [IDXW-1:0]  random_q
);
  localparam int PFNW = 22;
  localparam logic [IDXW-1:0] TOP = IDXW'(ENTRIES - 1);
  localparam logic [IDXW-1:0] LOW = IDXW'(WIRED);

  logic [20:0]      hi_vpn;
  logic [ASIDW-1:0] hi_asid;
  logic [PFNW-1:0]  l0_pfn, l1_pfn;
  logic             l0_d, l0_v, l0_g, l1_d, l1_v, l1_g;
  logic [7:0]       mask_r;
  logic             idx_fail;
  logic [IDXW-1:0]  idx_r, rnd;

  logic [20:0]      e_vpn  [ENTRIES];
  logic [ASIDW-1:0] e_asid [ENTRIES];
  logic [7:0]       e_mask [ENTRIES];
  logic             e_g    [ENTRIES];
  logic [PFNW+1:0]  e_lo0  [ENTRIES];
  logic [PFNW+1:0]  e_lo1  [ENTRIES];

  function automatic logic [7:0] eff_mask(input logic [7:0] m);
    case (m)
      8'h00, 8'h03, 8'h0F, 8'h3F, 8'hFF: eff_mask = m;
      default:                           eff_mask = 8'h00;
    endcase
  endfunction

  function automatic logic hit(input int i, input logic [20:0] vpn, input logic [ASIDW-1:0] asid);
    hit = (((vpn ^ e_vpn[i]) & ~{13'b0, eff_mask(e_mask[i])}) == 21'b0) &&
          (e_g[i] || (e_asid[i] == asid));
  endfunction

  logic            t_hit, p_hit;
  logic [IDXW-1:0] t_idx, p_idx;

  always_comb begin
    t_hit = 1'b0; t_idx = '0;
    p_hit = 1'b0; p_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit(i, xl_vaddr[31:11], xl_asid)) begin t_hit = 1'b1; t_idx = IDXW'(i); end
      if (hit(i, hi_vpn, hi_asid))           begin p_hit = 1'b1; p_idx = IDXW'(i); end
    end
  end

  logic [7:0]      t_mask;
  logic [4:0]      t_sel;
  logic [31:0]     t_off;
  logic [PFNW+1:0] t_lo;

  assign t_mask = eff_mask(e_mask[t_idx]);
  assign t_sel  = 5'd10 + 5'($countones(t_mask));
  assign t_off  = (32'h1 << t_sel) - 32'h1;
  assign t_lo   = xl_vaddr[t_sel] ? e_lo1[t_idx] : e_lo0[t_idx];

  always_comb begin
    if (!t_hit)                 xl_exc = 2'b01;
    else if (!t_lo[0])          xl_exc = 2'b10;
    else if (xl_store && !t_lo[1]) xl_exc = 2'b11;
    else                        xl_exc = 2'b00;
  end

  assign xl_paddr = (xl_exc != 2'b00) ? 32'h0 :
                    (({t_lo[PFNW+1:2], 10'b0} & ~t_off) | (xl_vaddr & t_off));

  logic [IDXW-1:0] w_idx;
  assign w_idx = cmd_wi ? idx_r : rnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0; e_asid[i] <= '0; e_mask[i] <= '0;
        e_g[i]   <= 1'b0; e_lo0[i] <= '0; e_lo1[i] <= '0;
      end
    end else if (cmd_wi || cmd_wr) begin
      e_vpn[w_idx]  <= hi_vpn;
      e_asid[w_idx] <= hi_asid;
      e_mask[w_idx] <= mask_r;
      e_g[w_idx]    <= l0_g & l1_g;
      e_lo0[w_idx]  <= {l0_pfn, l0_d, l0_v};
      e_lo1[w_idx]  <= {l1_pfn, l1_d, l1_v};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rnd <= TOP;
    else        rnd <= (rnd == LOW) ? TOP : rnd - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_vpn <= '0; hi_asid <= '0;
    end else if (mg_we && mg_sel == 3'd0) begin
      hi_vpn <= mg_wdata[31:11]; hi_asid <= mg_wdata[ASIDW-1:0];
    end else if (cmd_rd) begin
      hi_vpn <= e_vpn[idx_r]; hi_asid <= e_asid[idx_r];
    end else if (xl_valid && xl_exc != 2'b00) begin
      hi_vpn <= xl_vaddr[31:11]; hi_asid <= xl_asid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {l0_pfn, l0_d, l0_v, l0_g} <= '0;
      {l1_pfn, l1_d, l1_v, l1_g} <= '0;
      mask_r <= '0;
    end else if (mg_we) begin
      if (mg_sel == 3'd1) {l0_pfn, l0_d, l0_v, l0_g} <= {mg_wdata[25:4], mg_wdata[2:0]};
      if (mg_sel == 3'd2) {l1_pfn, l1_d, l1_v, l1_g} <= {mg_wdata[25:4], mg_wdata[2:0]};
      if (mg_sel == 3'd3) mask_r <= mg_wdata[18:11];
    end else if (cmd_rd) begin
      {l0_pfn, l0_d, l0_v} <= e_lo0[idx_r];
      {l1_pfn, l1_d, l1_v} <= e_lo1[idx_r];
      l0_g   <= e_g[idx_r];
      l1_g   <= e_g[idx_r];
      mask_r <= e_mask[idx_r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_fail <= 1'b0; idx_r <= '0;
    end else if (mg_we && mg_sel == 3'd4) begin
      idx_fail <= mg_wdata[31]; idx_r <= mg_wdata[IDXW-1:0];
    end else if (cmd_probe) begin
      idx_fail <= !p_hit; idx_r <= p_hit ? p_idx : '0;
    end
  end

  assign hi_q     = {hi_vpn, {(11-ASIDW){1'b0}}, hi_asid};
  assign lo0_q    = {6'b0, l0_pfn, 1'b0, l0_d, l0_v, l0_g};
  assign lo1_q    = {6'b0, l1_pfn, 1'b0, l1_d, l1_v, l1_g};
  assign mask_q   = {13'b0, mask_r, 11'b0};
  assign index_q  = {idx_fail, {(31-IDXW){1'b0}}, idx_r};
  assign random_q = rnd;
endmodule

// File: rtl/pgtlb_chk.sv
module pgtlb_chk #(
  parameter int ENTRIES = 8,
  parameter int WIRED   = 2,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xl_valid,
  input logic            xl_store,
  input logic [31:0]     xl_vaddr,
  input logic [1:0]      xl_exc,
  input logic            mg_we,
  input logic            cmd_rd,
  input logic            cmd_probe,
  input logic [31:0]     hi_q,
  input logic [31:0]     index_q,
  input logic [IDXW-1:0] random_q
);
  AST_MODIFIED_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_exc == 2'b11) |-> xl_store); // R6

  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_exc != 2'b00 && !mg_we && !cmd_rd) |=> (hi_q[31:11] == $past(xl_vaddr[31:11]))); // R7

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mg_we && !cmd_rd && !(xl_valid && xl_exc != 2'b00)) |=> $stable(hi_q)); // R7

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mg_we && !cmd_probe) |=> $stable(index_q)); // R8

  AST_RANDOM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (random_q >= IDXW'(WIRED)) && (random_q <= IDXW'(ENTRIES - 1))); // R10

  AST_RANDOM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (random_q != IDXW'(WIRED)) |=> (random_q == $past(random_q) - 1'b1)); // R10
endmodule

bind pgtlb pgtlb_chk #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_chk (
  .clk(clk), .rst_n(rst_n), .xl_valid(xl_valid), .xl_store(xl_store),
  .xl_vaddr(xl_vaddr), .xl_exc(xl_exc), .mg_we(mg_we), .cmd_rd(cmd_rd),
  .cmd_probe(cmd_probe), .hi_q(hi_q), .index_q(index_q), .random_q(random_q));

// File: tb/pgtlb_bench.sv
module pgtlb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_valid = 1'b0, xl_store = 1'b0;
  logic [31:0] xl_vaddr = '0;
  logic [7:0]  xl_asid = '0;
  logic [31:0] xl_paddr;
  logic [1:0]  xl_exc;
  logic        mg_we = 1'b0;
  logic [2:0]  mg_sel = '0;
  logic [31:0] mg_wdata = '0;
  logic        cmd_probe = 1'b0, cmd_wi = 1'b0, cmd_wr = 1'b0, cmd_rd = 1'b0;
  logic [31:0] hi_q, lo0_q, lo1_q, mask_q, index_q;
  logic [2:0]  random_q;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pgtlb u_pgtlb (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [21:0] pfn, input bit d, input bit v, input bit g);
    return {6'b0, pfn, 1'b0, d, v, g};
  endfunction

  task automatic mwr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); mg_we = 1'b1; mg_sel = s; mg_wdata = d;
    @(negedge clk); mg_we = 1'b0;
  endtask

  task automatic cmd(input int k);
    @(negedge clk);
    cmd_probe = (k == 0); cmd_wi = (k == 1); cmd_wr = (k == 2); cmd_rd = (k == 3);
    @(negedge clk);
    cmd_probe = 1'b0; cmd_wi = 1'b0; cmd_wr = 1'b0; cmd_rd = 1'b0;
  endtask

  task automatic load(input int idx, input logic [31:0] hi, input logic [31:0] m,
                      input logic [31:0] l0, input logic [31:0] l1);
    mwr(3'd4, 32'(idx)); mwr(3'd0, hi); mwr(3'd3, m); mwr(3'd1, l0); mwr(3'd2, l1);
    cmd(1);
  endtask

  task automatic xl(input string tag, input logic [31:0] va, input logic [7:0] asid, input bit st,
                    input logic [1:0] eexc, input logic [31:0] epa);
    @(negedge clk); xl_vaddr = va; xl_asid = asid; xl_store = st; xl_valid = 1'b0;
    #1;
    chk({tag, " exc"}, 32'(xl_exc), 32'(eexc));
    chk({tag, " paddr"}, xl_paddr, epa);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R1 hi", hi_q, 0); chk("R1 lo0", lo0_q, 0); chk("R1 lo1", lo1_q, 0);
    chk("R1 mask", mask_q, 0); chk("R1 index", index_q, 0); chk("R1 random", 32'(random_q), 7);
    rst_n = 1'b1;
  endtask

  task automatic t_mgmt;
    mwr(3'd0, 32'hFFFF_FFFF); chk("R2 hi", hi_q, 32'hFFFF_F8FF);
    mwr(3'd1, 32'hFFFF_FFFF); chk("R2 lo0", lo0_q, 32'h03FF_FFF7);
    mwr(3'd2, 32'hFFFF_FFFF); chk("R2 lo1", lo1_q, 32'h03FF_FFF7);
    mwr(3'd3, 32'hFFFF_FFFF); chk("R2 mask", mask_q, 32'h0007_F800);
    mwr(3'd4, 32'hFFFF_FFFF); chk("R2 index", index_q, 32'h8000_0007);
  endtask

  task automatic t_size4k;
    load(0, 32'h0040_0005, 32'h0000_1800, mk(22'h100, 1, 1, 0), mk(22'h200, 0, 1, 0));
    xl("R3 R4 even", 32'h0040_0ABC, 8'h05, 0, 2'b00, 32'h0004_0ABC);
    xl("R3 R4 odd", 32'h0040_1ABC, 8'h05, 0, 2'b00, 32'h0008_0ABC);
    xl("R6 modified", 32'h0040_1ABC, 8'h05, 1, 2'b11, 32'h0);
    xl("R6 store ok", 32'h0040_0ABC, 8'h05, 1, 2'b00, 32'h0004_0ABC);
    xl("R3 R6 miss", 32'h0040_2000, 8'h05, 0, 2'b01, 32'h0);
    xl("R5 asid miss", 32'h0040_0ABC, 8'h06, 0, 2'b01, 32'h0);
  endtask

  task automatic t_global;
    load(1, 32'h1000_0009, 32'h0, mk(22'h12345, 1, 1, 1), mk(22'h0, 0, 0, 1));
    xl("R5 global", 32'h1000_0123, 8'h33, 0, 2'b00, 32'h048D_1523);
    xl("R6 invalid", 32'h1000_0523, 8'h33, 0, 2'b10, 32'h0);
  endtask

  task automatic t_size256k;
    load(2, 32'h0080_0002, 32'h0007_F800, mk(22'h1000, 1, 1, 0), mk(22'h2000, 1, 1, 0));
    xl("R3 R4 256k odd", 32'h0087_1234, 8'h02, 0, 2'b00, 32'h0083_1234);
    xl("R3 R4 256k even", 32'h0083_0000, 8'h02, 0, 2'b00, 32'h0043_0000);
  endtask

  task automatic t_badmask;
    load(3, 32'h2000_0001, 32'h0000_2800, mk(22'h100, 1, 1, 0), mk(22'h200, 1, 1, 0));
    xl("R11 odd 1k", 32'h2000_0400, 8'h01, 0, 2'b00, 32'h0008_0000);
    xl("R11 bit11 miss", 32'h2000_0800, 8'h01, 0, 2'b01, 32'h0);
  endtask

  task automatic t_multi;
    load(5, 32'h3000_0004, 32'h0, mk(22'hAAA, 1, 1, 0), mk(22'h0, 0, 0, 0));
    load(6, 32'h3000_0004, 32'h0, mk(22'hBBB, 1, 1, 0), mk(22'h0, 0, 0, 0));
    xl("R12 lowest", 32'h3000_0010, 8'h04, 0, 2'b00, 32'h002A_A810);
  endtask

  task automatic t_capture;
    mwr(3'd0, 32'h0);
    @(negedge clk); xl_vaddr = 32'h0ABC_DE12; xl_asid = 8'h44; xl_store = 0; xl_valid = 1'b1;
    @(negedge clk); xl_valid = 1'b0;
    chk("R7 miss capture", hi_q, 32'h0ABC_D844);
    @(negedge clk); xl_vaddr = 32'h1000_0523; xl_asid = 8'h01; xl_valid = 1'b1;
    @(negedge clk); xl_valid = 1'b0;
    chk("R7 invalid capture", hi_q, 32'h1000_0001);
    @(negedge clk); xl_vaddr = 32'h0040_0ABC; xl_asid = 8'h05; xl_valid = 1'b1;
    @(negedge clk); xl_valid = 1'b0;
    chk("R7 hit no capture", hi_q, 32'h1000_0001);
  endtask

  task automatic t_probe;
    mwr(3'd0, 32'h0040_0005); cmd(0); chk("R8 probe hit", index_q, 32'h0);
    mwr(3'd0, 32'h0040_1005); cmd(0); chk("R8 probe masked", index_q, 32'h0);
    mwr(3'd0, 32'h1234_5003); cmd(0); chk("R8 probe miss", index_q, 32'h8000_0000);
    mwr(3'd0, 32'h1000_0077); cmd(0); chk("R8 R5 probe global", index_q, 32'h1);
  endtask

  task automatic t_read;
    mwr(3'd4, 32'h2); cmd(3);
    chk("R9 read hi", hi_q, 32'h0080_0002);
    chk("R9 read mask", mask_q, 32'h0007_F800);
    chk("R9 read lo0", lo0_q, mk(22'h1000, 1, 1, 0));
    chk("R9 read lo1", lo1_q, mk(22'h2000, 1, 1, 0));
    mwr(3'd4, 32'h1); cmd(3);
    chk("R9 read global lo1", lo1_q, mk(22'h0, 0, 0, 1));
  endtask

  task automatic t_random;
    logic [2:0] r, prev;
    mwr(3'd0, 32'h4000_0007); mwr(3'd3, 32'h0);
    mwr(3'd1, mk(22'h55, 1, 1, 0)); mwr(3'd2, mk(22'h0, 0, 0, 0));
    @(negedge clk); r = random_q; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    chk("R10 step", 32'(random_q), (r == 3'd2) ? 32'd7 : 32'(r - 3'd1));
    xl("R10 random entry", 32'h4000_0000, 8'h07, 0, 2'b00, 32'h0001_5400);
    mwr(3'd4, 32'(r)); cmd(3);
    chk("R10 random index", hi_q, 32'h4000_0007);
    for (int i = 0; i < 8; i++) begin
      prev = random_q;
      @(negedge clk);
      chk("R10 sequence", 32'(random_q), (prev == 3'd2) ? 32'd7 : 32'(prev - 3'd1));
    end
  endtask

  initial begin
    t_reset;
    t_mgmt;
    t_size4k;
    t_global;
    t_size256k;
    t_badmask;
    t_multi;
    t_capture;
    t_probe;
    t_read;
    t_random;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule